// File: doc/BRIEF.md
# Windowed Interrupt Array Register Bank

This block keeps three per-line state arrays for up to 512 external interrupt lines: an enable bit, a software force bit and a priority. Software reaches them through a narrow CSR port. Every access returns one 16-bit slice of one array. The slice is chosen by a small index carried in the low bits of the same access's write data. The pending status is read-only and is formed as the level-sensitive request input ORed with the force bit.

From this state the block drives a single registered machine external interrupt pending flag. The flag is high while at least one line is pending, enabled and has a priority at or above the current preemption level. The preemption level comes from outside. So does a "claimed" pulse from the next-interrupt arbiter, which retires the force bit of the line that was handed out.

Top module: `irq_window_bank`

## Requirements
- R1: A request (`csr_req` high for one cycle) is answered in the next cycle by `csr_ack` high for one cycle. `csr_rdata` returns the selected window as it was before any update made by that access. The arrays are at `BASE_ADDR` + 0 (enable), + 1 (pending), + 2 (force) and + 3 (priority). Any other address is acknowledged with zero data and changes nothing.
- R2: The window is returned in `csr_rdata[31:16]`, and `csr_rdata[15:0]` is zero. The window index is `csr_wdata[4:0]` for the write, set and clear operations. For the read operation the index is 0 whatever the write data holds, and the read operation changes nothing. Window k of a one-bit array covers lines 16k to 16k+15, with line 16k+j in bit 16+j.
- R3: `csr_op` is encoded as 0 read, 1 write, 2 set, 3 clear, and each operation acts only on the selected window. Write replaces it with `csr_wdata[31:16]`. Set ORs that value in. Clear removes the bits that are 1 in that value. No other window changes.
- R4: After reset all enable, force and priority state is zero, and `csr_ack` and `ext_irq_pend` are low.
- R5: A pending bit reads 1 while its `irq_req` input is high or its force bit is set. Writes to the pending array have no effect.
- R6: A `claim_vld` pulse clears the force bit of line `claim_irq`. A claim number at or above `NUM_IRQ` does nothing. If a software write, set or clear hits the force window in the same cycle, it is applied on top of the cleared value, so a bit that software sets survives.
- R7: Priority window i holds lines 4i to 4i+3, four bits each, with line 4i in bits 19:16. When `PRIO_BITS` is below 4, the low 4-`PRIO_BITS` bits of every field read as 0.
- R8: An index at or beyond the implemented windows reads as zero and ignores writes. The one-bit arrays have `NUM_IRQ`/16 windows. The priority array has min(`NUM_IRQ`,128)/4 windows, and lines from 128 upward have priority 0.
- R9: `ext_irq_pend` is high only when some line is pending and enabled and its priority, zero-extended to 5 bits, is greater than or equal to `preempt_lvl`. A level of 16 or more masks every line.
- R10: `ext_irq_pend` is registered. It follows a change of `irq_req` or `preempt_lvl` after one clock edge. It follows an array change made by a CSR access one edge after that access's update edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_req | input | 1 | CSR access strobe |
| csr_addr | input | 12 | CSR address |
| csr_op | input | 2 | Operation: 0 read, 1 write, 2 set, 3 clear |
| csr_wdata | input | 32 | Window value in 31:16, window index in 4:0 |
| csr_ack | output | 1 | Access completed, one cycle after the strobe |
| csr_rdata | output | 32 | Prior window value in 31:16 |
| irq_req | input | NUM_IRQ | Level-sensitive interrupt requests |
| preempt_lvl | input | 5 | Current preemption priority threshold |
| claim_vld | input | 1 | Arbiter handed out line `claim_irq` |
| claim_irq | input | 9 | Number of the claimed line |
| ext_irq_pend | output | 1 | Machine external interrupt pending |

## Verification
The functions that can collide are the claim-driven clearing of a force bit and a software set or write of the same force window. The bench raises `claim_vld` in the very cycle that a set operation targets the window holding the claimed line. It then reads the force window back. The claimed bit must be gone unless the set names it, and a bit the set names must remain. The same clash is repeated with the claim on a line that the set re-asserts.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  localparam int WIN_W     = 16;
  localparam int IDX_W     = 5;
  localparam int IRQ_NUM_W = 9;
  localparam int PRIO_W    = 4;
  localparam int LVL_W     = 5;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } csr_op_e;

  typedef enum logic [1:0] {
    ARR_ENABLE  = 2'd0,
    ARR_PENDING = 2'd1,
    ARR_FORCE   = 2'd2,
    ARR_PRIO    = 2'd3
  } arr_sel_e;

  // Apply one CSR operation to a 16-bit window.
  function automatic logic [WIN_W-1:0] win_apply(
    input logic [WIN_W-1:0] cur,
    input logic [WIN_W-1:0] data,
    input csr_op_e          op
  );
    logic [WIN_W-1:0] res;
    case (op)
      OP_WRITE: res = data;
      OP_SET:   res = cur | data;
      OP_CLEAR: res = cur & ~data;
      default:  res = cur;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/irq_csr_front.sv
module irq_csr_front
  import irq_bank_pkg::*;
#(
  parameter logic [11:0] BASE_ADDR = 12'h7C0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_req,
  input  logic [11:0]      csr_addr,
  input  logic [1:0]       csr_op,
  input  logic [31:0]      csr_wdata,
  input  logic [WIN_W-1:0] rd_win,
  output logic             sel_en,
  output logic             sel_pend,
  output logic             sel_force,
  output logic             sel_prio,
  output csr_op_e          op_o,
  output logic [IDX_W-1:0] win_idx,
  output logic [WIN_W-1:0] win_data,
  output logic             csr_ack,
  output logic [31:0]      csr_rdata
);

  logic        hit;
  logic        ack_d;
  logic [31:0] rdata_d;
  logic        unused_wdata;

  assign hit      = csr_req && (csr_addr[11:2] == BASE_ADDR[11:2]);
  assign op_o     = csr_op_e'(csr_op);
  assign win_data = csr_wdata[31:16];
  assign win_idx  = (op_o == OP_READ) ? '0 : csr_wdata[IDX_W-1:0];

  assign sel_en    = hit && (csr_addr[1:0] == ARR_ENABLE);
  assign sel_pend  = hit && (csr_addr[1:0] == ARR_PENDING);
  assign sel_force = hit && (csr_addr[1:0] == ARR_FORCE);
  assign sel_prio  = hit && (csr_addr[1:0] == ARR_PRIO);

  assign unused_wdata = ^csr_wdata[15:IDX_W];

  always_comb begin
    ack_d   = csr_req;
    rdata_d = hit ? {rd_win, 16'h0000} : 32'h0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_ack   <= 1'b0;
      csr_rdata <= '0;
    end else begin
      csr_ack <= ack_d;
      if (csr_req) csr_rdata <= rdata_d;
    end
  end

  // R1: the acknowledge follows every strobe by exactly one cycle
  a_r1_ack_after_req : assert property (@(posedge clk) disable iff (!rst_n)
    csr_req |=> csr_ack);
  a_r1_no_spurious_ack : assert property (@(posedge clk) disable iff (!rst_n)
    !csr_req |=> !csr_ack);
  // R1: an unmapped address answers with zero data
  a_r1_unmapped_zero : assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req && !hit) |=> (csr_rdata == 32'h0));

endmodule

// File: rtl/irq_bit_array.sv
module irq_bit_array
  import irq_bank_pkg::*;
#(
  parameter int NUM_IRQ   = 64,
  parameter bit CLAIM_CLR = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel,
  input  csr_op_e              op,
  input  logic [IDX_W-1:0]     idx,
  input  logic [WIN_W-1:0]     wdata,
  input  logic                 claim_vld,
  input  logic [IRQ_NUM_W-1:0] claim_irq,
  output logic [NUM_IRQ-1:0]   bits_o,
  output logic [WIN_W-1:0]     rd_win
);

  localparam int NWIN = NUM_IRQ / WIN_W;

  logic wr_req;
  logic idx_ok;

  assign wr_req = sel && (op != OP_READ);
  assign idx_ok = int'(idx) < NWIN;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    logic [WIN_W-1:0] win_q;
    logic [WIN_W-1:0] win_d;
    logic [WIN_W-1:0] clr_mask;
    logic             sw_hit;
    logic             claim_hit;
    logic             win_en;

    assign sw_hit = wr_req && (idx == IDX_W'(w));

    if (CLAIM_CLR) begin : g_claim
      assign claim_hit = claim_vld &&
                         (claim_irq[IRQ_NUM_W-1:4] == (IRQ_NUM_W-4)'(w));
      assign clr_mask  = claim_hit ? (WIN_W'(1) << claim_irq[3:0]) : '0;
    end else begin : g_noclaim
      assign claim_hit = 1'b0;
      assign clr_mask  = '0;
    end

    // claim clear first, software operation on top of it
    always_comb begin
      win_d = win_q & ~clr_mask;
      if (sw_hit) win_d = win_apply(win_d, wdata, op);
    end

    assign win_en = sw_hit || claim_hit;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      win_q <= '0;
      else if (win_en) win_q <= win_d;
    end

    assign bits_o[w*WIN_W +: WIN_W] = win_q;
  end

  if (!CLAIM_CLR) begin : g_unused
    logic unused_claim;
    assign unused_claim = ^{claim_vld, claim_irq};
  end

  always_comb begin
    rd_win = '0;
    if (idx_ok) rd_win = bits_o[{idx, 4'b0000} +: WIN_W];
  end

  // R8: writes through an unimplemented window leave the array untouched
  a_r8_oob_write_ignored : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !idx_ok && !claim_vld) |=> $stable(bits_o));

  if (CLAIM_CLR) begin : g_claim_chk
    // R6: a claim without a concurrent software access retires the bit
    a_r6_claim_clears : assert property (@(posedge clk) disable iff (!rst_n)
      (claim_vld && (int'(claim_irq) < NUM_IRQ) && !wr_req)
      |=> !bits_o[$past(claim_irq)]);
  end

endmodule

// File: rtl/irq_prio_array.sv
module irq_prio_array
  import irq_bank_pkg::*;
#(
  parameter int NUM_IRQ   = 64,
  parameter int PRIO_BITS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sel,
  input  csr_op_e                   op,
  input  logic [IDX_W-1:0]          idx,
  input  logic [WIN_W-1:0]          wdata,
  output logic [NUM_IRQ*PRIO_W-1:0] prio_o,
  output logic [WIN_W-1:0]          rd_win
);

  localparam int NP   = (NUM_IRQ < 128) ? NUM_IRQ : 128;
  localparam int FPW  = WIN_W / PRIO_W;
  localparam int NPW  = NP / FPW;
  localparam int PAD  = PRIO_W - PRIO_BITS;

  logic wr_req;
  logic idx_ok;

  assign wr_req = sel && (op != OP_READ);
  assign idx_ok = int'(idx) < NPW;

  for (genvar w = 0; w < NPW; w++) begin : g_win
    logic [FPW*PRIO_BITS-1:0] st_q;
    logic [FPW*PRIO_BITS-1:0] st_d;
    logic [WIN_W-1:0]         old_w;
    logic [WIN_W-1:0]         new_w;
    logic                     sw_hit;

    assign sw_hit = wr_req && (idx == IDX_W'(w));
    assign new_w  = win_apply(old_w, wdata, op);

    for (genvar n = 0; n < FPW; n++) begin : g_fld
      if (PAD == 0) begin : g_full
        assign old_w[n*PRIO_W +: PRIO_W] = st_q[n*PRIO_BITS +: PRIO_BITS];
      end else begin : g_pad
        logic unused_lsb;
        assign old_w[n*PRIO_W +: PRIO_W] =
          {st_q[n*PRIO_BITS +: PRIO_BITS], {PAD{1'b0}}};
        assign unused_lsb = ^new_w[n*PRIO_W +: PAD];
      end
      assign st_d[n*PRIO_BITS +: PRIO_BITS] = new_w[n*PRIO_W + PAD +: PRIO_BITS];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      st_q <= '0;
      else if (sw_hit) st_q <= st_d;
    end

    assign prio_o[w*WIN_W +: WIN_W] = old_w;
  end

  if (NUM_IRQ > NP) begin : g_hi
    assign prio_o[NUM_IRQ*PRIO_W-1:NP*PRIO_W] = '0;
  end

  always_comb begin
    rd_win = '0;
    if (idx_ok) rd_win = prio_o[{idx, 4'b0000} +: WIN_W];
  end

  // R8: an out-of-range priority window ignores writes
  a_r8_prio_oob_ignored : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !idx_ok) |=> $stable(prio_o));
  // R2: a plain read never alters priorities
  a_r2_prio_read_pure : assert property (@(posedge clk) disable iff (!rst_n)
    (sel && op == OP_READ) |=> $stable(prio_o));

endmodule

// File: rtl/irq_window_bank.sv
module irq_window_bank
  import irq_bank_pkg::*;
#(
  parameter int          NUM_IRQ   = 64,
  parameter int          PRIO_BITS = 4,
  parameter logic [11:0] BASE_ADDR = 12'h7C0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               csr_req,
  input  logic [11:0]        csr_addr,
  input  logic [1:0]         csr_op,
  input  logic [31:0]        csr_wdata,
  output logic               csr_ack,
  output logic [31:0]        csr_rdata,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [4:0]         preempt_lvl,
  input  logic               claim_vld,
  input  logic [8:0]         claim_irq,
  output logic               ext_irq_pend
);

  localparam int NWIN = NUM_IRQ / WIN_W;

  logic                      sel_en, sel_pend, sel_force, sel_prio;
  csr_op_e                   op;
  logic [IDX_W-1:0]          win_idx;
  logic [WIN_W-1:0]          win_data;
  logic [WIN_W-1:0]          rd_win;
  logic [WIN_W-1:0]          en_rd, force_rd, prio_rd, pend_rd;
  logic [NUM_IRQ-1:0]        en_bits, force_bits, pend_bits, elig;
  logic [NUM_IRQ*PRIO_W-1:0] prio_flat;
  logic                      meip_d;

  irq_csr_front #(.BASE_ADDR(BASE_ADDR)) u_front (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_req   (csr_req),
    .csr_addr  (csr_addr),
    .csr_op    (csr_op),
    .csr_wdata (csr_wdata),
    .rd_win    (rd_win),
    .sel_en    (sel_en),
    .sel_pend  (sel_pend),
    .sel_force (sel_force),
    .sel_prio  (sel_prio),
    .op_o      (op),
    .win_idx   (win_idx),
    .win_data  (win_data),
    .csr_ack   (csr_ack),
    .csr_rdata (csr_rdata)
  );

  irq_bit_array #(.NUM_IRQ(NUM_IRQ), .CLAIM_CLR(1'b0)) u_enable (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel_en),
    .op        (op),
    .idx       (win_idx),
    .wdata     (win_data),
    .claim_vld (1'b0),
    .claim_irq ('0),
    .bits_o    (en_bits),
    .rd_win    (en_rd)
  );

  irq_bit_array #(.NUM_IRQ(NUM_IRQ), .CLAIM_CLR(1'b1)) u_force (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel_force),
    .op        (op),
    .idx       (win_idx),
    .wdata     (win_data),
    .claim_vld (claim_vld),
    .claim_irq (claim_irq),
    .bits_o    (force_bits),
    .rd_win    (force_rd)
  );

  irq_prio_array #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) u_prio (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (sel_prio),
    .op     (op),
    .idx    (win_idx),
    .wdata  (win_data),
    .prio_o (prio_flat),
    .rd_win (prio_rd)
  );

  // pending status: level requests merged with software force
  assign pend_bits = irq_req | force_bits;

  always_comb begin
    pend_rd = '0;
    if (int'(win_idx) < NWIN) pend_rd = pend_bits[{win_idx, 4'b0000} +: WIN_W];
  end

  always_comb begin
    if (sel_en)         rd_win = en_rd;
    else if (sel_pend)  rd_win = pend_rd;
    else if (sel_force) rd_win = force_rd;
    else if (sel_prio)  rd_win = prio_rd;
    else                rd_win = '0;
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_elig
    assign elig[i] = pend_bits[i] && en_bits[i] &&
                     ({1'b0, prio_flat[i*PRIO_W +: PRIO_W]} >= preempt_lvl);
  end

  assign meip_d = |elig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_irq_pend <= 1'b0;
    else        ext_irq_pend <= meip_d;
  end

  // R9: the flag never rises without an enabled pending line behind it
  a_r9_meip_has_source : assert property (@(posedge clk) disable iff (!rst_n)
    ext_irq_pend |-> $past(|(pend_bits & en_bits)));
  // R9: a mask level above every priority keeps the flag low next cycle
  a_r9_mask_all : assert property (@(posedge clk) disable iff (!rst_n)
    (preempt_lvl >= 5'd16) |=> !ext_irq_pend);

endmodule

// File: tb/tb_irq_window_bank.sv
`timescale 1ns/1ps
module tb_irq_window_bank;

  localparam logic [11:0] BASE    = 12'h7C0;
  localparam logic [11:0] A_EN    = BASE + 12'd0;
  localparam logic [11:0] A_PEND  = BASE + 12'd1;
  localparam logic [11:0] A_FORCE = BASE + 12'd2;
  localparam logic [11:0] A_PRIO  = BASE + 12'd3;
  localparam logic [1:0]  OPR = 2'd0, OPW = 2'd1, OPS = 2'd2, OPC = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_req = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [1:0]  csr_op = '0;
  logic [31:0] csr_wdata = '0;
  logic        csr_ack, csr_ack2;
  logic [31:0] csr_rdata, csr_rdata2;
  logic [63:0] irq_req = '0;
  logic [4:0]  preempt_lvl = '0;
  logic        claim_vld = 1'b0;
  logic [8:0]  claim_irq = '0;
  logic        meip, meip2;

  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;
  logic        ack_last;
  logic [31:0] rd_last, rd2_last;

  always #2.5 clk = ~clk;

  irq_window_bank #(.NUM_IRQ(64), .PRIO_BITS(4), .BASE_ADDR(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .csr_req(csr_req), .csr_addr(csr_addr),
    .csr_op(csr_op), .csr_wdata(csr_wdata), .csr_ack(csr_ack),
    .csr_rdata(csr_rdata), .irq_req(irq_req), .preempt_lvl(preempt_lvl),
    .claim_vld(claim_vld), .claim_irq(claim_irq), .ext_irq_pend(meip)
  );

  irq_window_bank #(.NUM_IRQ(32), .PRIO_BITS(2), .BASE_ADDR(BASE)) dut_p2 (
    .clk(clk), .rst_n(rst_n), .csr_req(csr_req), .csr_addr(csr_addr),
    .csr_op(csr_op), .csr_wdata(csr_wdata), .csr_ack(csr_ack2),
    .csr_rdata(csr_rdata2), .irq_req(32'h0), .preempt_lvl(preempt_lvl),
    .claim_vld(1'b0), .claim_irq(9'h0), .ext_irq_pend(meip2)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic csr_acc(input logic [1:0] op, input logic [11:0] addr,
                         input logic [4:0] idx, input logic [15:0] data);
    csr_req   = 1'b1;
    csr_addr  = addr;
    csr_op    = op;
    csr_wdata = {data, 11'h000, idx};
    tick();
    ack_last  = csr_ack;
    rd_last   = csr_rdata;
    rd2_last  = csr_rdata2;
    csr_req   = 1'b0;
    csr_op    = '0;
    csr_wdata = '0;
  endtask

  // set of zero: selects a window without altering it
  task automatic peek(input logic [11:0] addr, input logic [4:0] idx);
    csr_acc(OPS, addr, idx, 16'h0000);
  endtask

  task automatic t_reset();
    chk("R4 ack in reset", {31'b0, csr_ack}, 32'h0);
    chk("R4 meip in reset", {31'b0, meip}, 32'h0);
    @(negedge clk) rst_n = 1'b1;
    tick();
    csr_acc(OPR, A_EN, 5'd0, 16'h0);
    chk("R4 enable zero", rd_last, 32'h0);
    csr_acc(OPR, A_FORCE, 5'd0, 16'h0);
    chk("R4 force zero", rd_last, 32'h0);
    csr_acc(OPR, A_PRIO, 5'd0, 16'h0);
    chk("R4 priority zero", rd_last, 32'h0);
  endtask

  task automatic t_handshake();
    csr_acc(OPW, A_EN, 5'd0, 16'h1234);
    chk("R1 ack one cycle after req", {31'b0, ack_last}, 32'h1);
    tick();
    chk("R1 ack drops", {31'b0, csr_ack}, 32'h0);
    csr_acc(OPW, BASE + 12'd4, 5'd0, 16'hFFFF);
    chk("R1 unmapped ack", {31'b0, ack_last}, 32'h1);
    chk("R1 unmapped data zero", rd_last, 32'h0);
    csr_acc(OPR, A_EN, 5'd0, 16'h0);
    chk("R1 unmapped no effect", rd_last, 32'h1234_0000);
  endtask

  task automatic t_ops();
    csr_acc(OPW, A_EN, 5'd1, 16'hA5A5);
    chk("R1 write returns old", rd_last, 32'h0);
    csr_acc(OPS, A_EN, 5'd1, 16'h000F);
    chk("R1 set returns prior", rd_last, 32'hA5A5_0000);
    peek(A_EN, 5'd1);
    chk("R3 set ORs", rd_last, 32'hA5AF_0000);
    csr_acc(OPC, A_EN, 5'd1, 16'h00A0);
    peek(A_EN, 5'd1);
    chk("R3 clear removes bits", rd_last, 32'hA50F_0000);
    csr_acc(OPR, A_EN, 5'd1, 16'hFFFF);
    chk("R2 read uses window 0", rd_last, 32'h1234_0000);
    peek(A_EN, 5'd1);
    chk("R2 read leaves window 1", rd_last, 32'hA50F_0000);
    peek(A_EN, 5'd0);
    chk("R3 window 0 untouched", rd_last, 32'h1234_0000);
  endtask

  task automatic t_pending();
    irq_req[17] = 1'b1;
    peek(A_PEND, 5'd1);
    chk("R5 request shows pending", rd_last, 32'h0002_0000);
    csr_acc(OPW, A_PEND, 5'd1, 16'hFFFF);
    peek(A_PEND, 5'd1);
    chk("R5 pending write ignored", rd_last, 32'h0002_0000);
    csr_acc(OPS, A_FORCE, 5'd2, 16'h0008);
    peek(A_PEND, 5'd2);
    chk("R5 force shows pending", rd_last, 32'h0008_0000);
    irq_req[17] = 1'b0;
    peek(A_PEND, 5'd1);
    chk("R5 level drop clears", rd_last, 32'h0);
  endtask

  task automatic t_claim();
    claim_vld = 1'b1;
    claim_irq = 9'd35;
    tick();
    claim_vld = 1'b0;
    peek(A_FORCE, 5'd2);
    chk("R6 claim clears force", rd_last, 32'h0);
    csr_acc(OPW, A_FORCE, 5'd2, 16'h0300);
    claim_vld = 1'b1;
    claim_irq = 9'd41;
    csr_acc(OPS, A_FORCE, 5'd2, 16'h0100);
    claim_vld = 1'b0;
    peek(A_FORCE, 5'd2);
    chk("R6 claim with concurrent set", rd_last, 32'h0100_0000);
    claim_vld = 1'b1;
    claim_irq = 9'd40;
    csr_acc(OPS, A_FORCE, 5'd2, 16'h0100);
    claim_vld = 1'b0;
    peek(A_FORCE, 5'd2);
    chk("R6 software set wins", rd_last, 32'h0100_0000);
    claim_vld = 1'b1;
    claim_irq = 9'd300;
    tick();
    claim_vld = 1'b0;
    peek(A_FORCE, 5'd2);
    chk("R6 out-of-range claim", rd_last, 32'h0100_0000);
  endtask

  task automatic t_prio();
    csr_acc(OPW, A_PRIO, 5'd1, 16'h4321);
    peek(A_PRIO, 5'd1);
    chk("R7 priority window", rd_last, 32'h4321_0000);
    csr_acc(OPR, A_PRIO, 5'd0, 16'h0);
    chk("R7 window 0 separate", rd_last, 32'h0);
    csr_acc(OPW, A_PRIO, 5'd0, 16'hFFFF);
    peek(A_PRIO, 5'd0);
    chk("R7 low bits read zero", rd2_last, 32'hCCCC_0000);
    csr_acc(OPC, A_PRIO, 5'd0, 16'hFFFF);
    csr_acc(OPS, A_PRIO, 5'd0, 16'h0001);
    peek(A_PRIO, 5'd0);
    chk("R7 low bit not stored", rd2_last, 32'h0);
  endtask

  task automatic t_oob();
    csr_acc(OPW, A_EN, 5'd5, 16'hFFFF);
    chk("R8 oob reads zero", rd_last, 32'h0);
    peek(A_EN, 5'd5);
    chk("R8 oob stays zero", rd_last, 32'h0);
    peek(A_EN, 5'd3);
    chk("R8 top window intact", rd_last, 32'h0);
    peek(A_EN, 5'd1);
    chk("R8 window 1 intact", rd_last, 32'hA50F_0000);
    csr_acc(OPW, A_PRIO, 5'd20, 16'hFFFF);
    peek(A_PRIO, 5'd20);
    chk("R8 prio oob zero", rd_last, 32'h0);
    csr_acc(OPW, A_PRIO, 5'd8, 16'hFFFF);
    peek(A_PRIO, 5'd8);
    chk("R8 small prio oob zero", rd2_last, 32'h0);
    chk("R8 window 8 in range", rd_last, 32'hFFFF_0000);
  endtask

  task automatic t_meip();
    for (int w = 0; w < 4; w++) begin
      csr_acc(OPW, A_EN, 5'(w), 16'h0);
      csr_acc(OPW, A_FORCE, 5'(w), 16'h0);
    end
    irq_req = '0;
    preempt_lvl = 5'd0;
    tick();
    tick();
    chk("R9 idle low", {31'b0, meip}, 32'h0);
    csr_acc(OPS, A_EN, 5'd0, 16'h0020);
    irq_req[5] = 1'b1;
    tick();
    chk("R10 one edge after request", {31'b0, meip}, 32'h1);
    preempt_lvl = 5'd3;
    tick();
    chk("R9 below level masked", {31'b0, meip}, 32'h0);
    preempt_lvl = 5'd2;
    tick();
    chk("R9 equal level passes", {31'b0, meip}, 32'h1);
    preempt_lvl = 5'd16;
    tick();
    chk("R9 level 16 masks all", {31'b0, meip}, 32'h0);
    preempt_lvl = 5'd0;
    tick();
    chk("R9 reopened", {31'b0, meip}, 32'h1);
    csr_acc(OPC, A_EN, 5'd0, 16'h0020);
    chk("R10 csr change lags", {31'b0, meip}, 32'h1);
    tick();
    chk("R9 disabled line low", {31'b0, meip}, 32'h0);
    irq_req[5] = 1'b0;
    csr_acc(OPS, A_EN, 5'd0, 16'h0040);
    csr_acc(OPS, A_FORCE, 5'd0, 16'h0040);
    chk("R10 force lags", {31'b0, meip}, 32'h0);
    tick();
    chk("R5 force raises flag", {31'b0, meip}, 32'h1);
    claim_vld = 1'b1;
    claim_irq = 9'd6;
    tick();
    claim_vld = 1'b0;
    tick();
    chk("R6 claim drops flag", {31'b0, meip}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_handshake();
    t_ops();
    t_pending();
    t_claim();
    t_prio();
    t_oob();
    t_meip();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule